// File: doc/BRIEF.md
# Dual Mode Display Link Arbiter

This block decides how a display identification memory talks to its host. After reset the memory streams data out on its own transmit clock (transmit-only mode). The first falling edge on the two-wire bus clock moves the block into a transition state. In that state it behaves as a bus slave and watches for a START condition followed by a device select byte. A matching device select locks it into bus mode for good. If no match arrives before a bounded number of transmit-clock pulses, or before a timeout measured in system clock cycles, the block drops back to transmit-only mode. Each falling edge of the bus clock during the transition state restarts both of these limits.

Once the block is locked, a write-permit output qualifies write access to the memory. By default the level of the transmit clock serves as an active-high write enable. A build option replaces it with an active-low write-control input. The memory array, the shift-out path and the bus transfer engine sit outside this block.

Top module: `dmode_arbiter`

## Requirements
- R1: After reset `mode` is 2'd0 (transmit-only) and `writePermit` is 0. The mode encoding is 2'd0 transmit-only, 2'd1 transition, 2'd2 bus locked.
- R2: In transmit-only mode, a falling edge of SCL moves `mode` to transition. No other event changes transmit-only mode.
- R3: In the transition state, `mode` returns to transmit-only once VCLK_LIMIT rising edges of VCLK have been counted without a lock (default 128). After one pulse fewer, it is still in the transition state.
- R4: In the transition state, `mode` returns to transmit-only about TIMEOUT_CYCLES system clock cycles after the last restart if no lock has occurred.
- R5: Every SCL falling edge during the transition state clears both the VCLK pulse count and the timeout count. Both then count again from zero.
- R6: A START is SDA falling while SCL is high. The next eight SCL rising edges sample SDA with the MSB first. With WIDE_MATCH=0, the block locks when the upper seven bits equal 7'b1010000, whatever the eighth (read/write) bit is.
- R7: With WIDE_MATCH=1, any upper seven bits of the form 1010xxx lock the block. A byte that does not match leaves the block in the transition state.
- R8: Bus locked mode is left only by reset. VCLK pulses and elapsed time have no effect on it.
- R9: With HAS_WC=0, `writePermit` is 1 only while the block is locked and VCLK is high. It is 0 in every other mode, whatever the level of VCLK.
- R10: With HAS_WC=1, `writePermit` is 1 only while the block is locked and `wcIn` is low. An unused `wcIn` is tied low.
- R11: SCL, SDA, VCLK and the write control each pass through two synchronising flip-flops. An SCL fall therefore changes `mode` on the third system clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Two-wire bus clock line (asynchronous) |
| sdaIn | input | 1 | Two-wire bus data line (asynchronous) |
| vclkIn | input | 1 | Dedicated transmit clock; write enable when locked |
| wcIn | input | 1 | Active-low write control (used when HAS_WC=1) |
| mode | output | 2 | Current operating mode |
| writePermit | output | 1 | Write access allowed |

## Verification
The bench sweeps all 128 seven-bit addresses through an exact-match instance and a wide-match instance at the same time. This exposes a decoder that compares the wrong bits or that locks on a mismatch. It places the fallback exactly at the 127th and 128th VCLK pulse, so an off-by-one counter would fall back a pulse early or late. It also shows that an SCL fall in mid-count restarts both the pulse limit and the timeout; a design that ignored the restart would fall back too early. After a lock it applies many VCLK pulses and a long idle time, which would knock a non-sticky lock back to transmit-only. It then checks that the write permit follows VCLK, or the write control, only in locked mode.

// File: rtl/dmode_pkg.sv
package dmode_pkg;

  typedef enum logic [1:0] {
    MODE_TX     = 2'd0,
    MODE_TRANS  = 2'd1,
    MODE_LOCKED = 2'd2
  } modeState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCounters;
    logic countEnable;
  } ctlStrobes_t;

  // datapath -> control events
  typedef struct packed {
    logic sclFall;
    logic byteDone;
    logic addrMatch;
    logic vclkExpired;
    logic timeExpired;
  } busEvents_t;

endpackage

// File: rtl/dmode_datapath.sv
module dmode_datapath
  import dmode_pkg::*;
#(
  parameter int VCLK_LIMIT     = 128,
  parameter int TIMEOUT_CYCLES = 100_000_000,
  parameter bit WIDE_MATCH     = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        vclkIn,
  input  logic        wcIn,
  input  ctlStrobes_t ctl,
  output busEvents_t  ev,
  output logic        vclkLevel,
  output logic        wcLevel
);

  localparam int NLINES = 4;
  localparam int VW = $clog2(VCLK_LIMIT + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [NLINES-1:0] IDLE = 4'b0011; // bit0 scl, bit1 sda, bit2 vclk, bit3 wc
  localparam logic [VW-1:0] VMAX = VW'(VCLK_LIMIT);
  localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_CYCLES);

  logic [NLINES-1:0] rawIn, syncA, syncB, syncD;
  assign rawIn = {wcIn, vclkIn, sdaIn, sclIn};

  // two-stage synchronisers plus one delay stage for edge detection
  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[i] <= IDLE[i];
        syncB[i] <= IDLE[i];
        syncD[i] <= IDLE[i];
      end else begin
        syncA[i] <= rawIn[i];
        syncB[i] <= syncA[i];
        syncD[i] <= syncB[i];
      end
    end
  end

  logic sclRise, sclFall, sdaFall, vclkRise, startSeen;
  assign sclRise   = syncB[0] & ~syncD[0];
  assign sclFall   = ~syncB[0] & syncD[0];
  assign sdaFall   = ~syncB[1] & syncD[1];
  assign vclkRise  = syncB[2] & ~syncD[2];
  assign startSeen = sdaFall & syncB[0] & syncD[0];

  // device select shifter
  logic       armed, doneQ, matchQ, matchComb;
  logic [2:0] bitCnt;
  logic [6:0] addrBits;

  assign matchComb = WIDE_MATCH ? (addrBits[6:3] == 4'b1010)
                                : (addrBits == 7'b1010000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      bitCnt   <= '0;
      addrBits <= '0;
      doneQ    <= 1'b0;
      matchQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startSeen) begin
        armed  <= 1'b1;
        bitCnt <= '0;
      end else if (armed && sclRise) begin
        if (bitCnt == 3'd7) begin
          armed  <= 1'b0;
          doneQ  <= 1'b1;
          matchQ <= matchComb;
        end else begin
          addrBits <= {addrBits[5:0], syncB[1]};
          bitCnt   <= bitCnt + 3'd1;
        end
      end
    end
  end

  // fallback counters
  logic [VW-1:0] vclkCnt;
  logic [TW-1:0] timeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vclkCnt <= '0;
      timeCnt <= '0;
    end else if (ctl.clrCounters) begin
      vclkCnt <= '0;
      timeCnt <= '0;
    end else if (ctl.countEnable) begin
      if (vclkRise && vclkCnt != VMAX) vclkCnt <= vclkCnt + 1'b1;
      if (timeCnt != TMAX) timeCnt <= timeCnt + 1'b1;
    end
  end

  assign ev.sclFall     = sclFall;
  assign ev.byteDone    = doneQ;
  assign ev.addrMatch   = matchQ;
  assign ev.vclkExpired = (vclkCnt == VMAX);
  assign ev.timeExpired = (timeCnt == TMAX);
  assign vclkLevel      = syncB[2];
  assign wcLevel        = syncB[3];

  // R3 / R4: counters never pass their limits
  p_vclk_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    vclkCnt <= VMAX);
  p_time_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeCnt <= TMAX);
  // R5: a clear strobe empties both counters
  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCounters |=> (vclkCnt == '0) && (timeCnt == '0));

endmodule

// File: rtl/dmode_control.sv
module dmode_control
  import dmode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvents_t  ev,
  output ctlStrobes_t ctl,
  output modeState_t  state
);

  modeState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      MODE_TX:     if (ev.sclFall) nextState = MODE_TRANS;
      MODE_TRANS: begin
        if (ev.byteDone && ev.addrMatch)          nextState = MODE_LOCKED;
        else if (ev.sclFall)                      nextState = MODE_TRANS;
        else if (ev.vclkExpired || ev.timeExpired) nextState = MODE_TX;
      end
      MODE_LOCKED: nextState = MODE_LOCKED;
      default:     nextState = MODE_TX;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_TX;
    else       state <= nextState;
  end

  assign ctl.clrCounters = (state != MODE_TRANS) || ev.sclFall;
  assign ctl.countEnable = (state == MODE_TRANS);

  // R8: lock is sticky
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == MODE_LOCKED |=> state == MODE_LOCKED);
  // R2: transmit-only never jumps straight to lock
  p_no_direct_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == MODE_TX |=> state != MODE_LOCKED);
  // R3: an expired limit without restart or lock falls back
  p_fallback_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_TRANS && (ev.vclkExpired || ev.timeExpired) && !ev.sclFall && !ev.byteDone)
      |=> state == MODE_TX);

endmodule

// File: rtl/dmode_arbiter.sv
module dmode_arbiter
  import dmode_pkg::*;
#(
  parameter int VCLK_LIMIT     = 128,
  parameter int TIMEOUT_CYCLES = 100_000_000,
  parameter bit WIDE_MATCH     = 1'b0,
  parameter bit HAS_WC         = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       vclkIn,
  input  logic       wcIn,
  output logic [1:0] mode,
  output logic       writePermit
);

  ctlStrobes_t ctl;
  busEvents_t  ev;
  modeState_t  state;
  logic        vclkLevel, wcLevel;

  dmode_datapath #(
    .VCLK_LIMIT(VCLK_LIMIT),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .WIDE_MATCH(WIDE_MATCH)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .vclkIn(vclkIn), .wcIn(wcIn), .ctl(ctl), .ev(ev),
    .vclkLevel(vclkLevel), .wcLevel(wcLevel)
  );

  dmode_control u_control (
    .clk(clk), .rstN(rstN), .ev(ev), .ctl(ctl), .state(state)
  );

  assign mode        = state;
  assign writePermit = (state == MODE_LOCKED) && (HAS_WC ? !wcLevel : vclkLevel);

  // R9 / R10: writes only ever permitted in bus locked mode
  p_wp_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    writePermit |-> mode == 2'd2);

endmodule

// File: tb/dmode_arbiter_bench.sv
module dmode_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 128;
  localparam int TMO        = 2000;
  localparam int HB         = 4;
  localparam logic [1:0] TX = 2'd0, TR = 2'd1, LK = 2'd2;

  logic clk = 1'b0, rstN = 1'b0;
  logic scl = 1'b1, sda = 1'b1, vclk = 1'b0, wc = 1'b0;
  logic [1:0] modeE, modeW;
  logic wpE, wpW;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmode_arbiter #(.VCLK_LIMIT(LIMIT), .TIMEOUT_CYCLES(TMO), .WIDE_MATCH(1'b0), .HAS_WC(1'b0))
    u_dmode_arbiter (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .vclkIn(vclk),
                     .wcIn(wc), .mode(modeE), .writePermit(wpE));

  dmode_arbiter #(.VCLK_LIMIT(LIMIT), .TIMEOUT_CYCLES(TMO), .WIDE_MATCH(1'b1), .HAS_WC(1'b1))
    u_dmode_arbiter_wide (.clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .vclkIn(vclk),
                          .wcIn(wc), .mode(modeW), .writePermit(wpW));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkMode(input logic [1:0] act, input logic [1:0] exp, input string tag);
    check(act == exp, tag, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic doReset();
    cyc(1); rstN = 1'b0; scl = 1'b1; sda = 1'b1; vclk = 1'b0; wc = 1'b0;
    cyc(3); rstN = 1'b1; cyc(3);
  endtask

  task automatic vclkPulses(input int n);
    for (int i = 0; i < n; i++) begin
      vclk = 1'b1; cyc(3);
      vclk = 1'b0; cyc(3);
    end
  endtask

  task automatic sclDip();
    scl = 1'b1; cyc(HB);
    scl = 1'b0; cyc(HB + 2);
  endtask

  task automatic sendSelect(input logic [7:0] b);
    scl = 1'b1; sda = 1'b1; cyc(HB);
    sda = 1'b0; cyc(HB);
    scl = 1'b0; cyc(HB);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; cyc(HB);
      scl = 1'b1; cyc(HB);
      scl = 1'b0; cyc(HB);
    end
    sda = 1'b0; cyc(HB);
    scl = 1'b1; cyc(HB);
    scl = 1'b0; cyc(HB);
    sda = 1'b1; cyc(HB + 6);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    doReset();
    // R1 reset state, even with VCLK high
    vclk = 1'b1; cyc(4); sample();
    checkMode(modeE, TX, "R1 mode after reset");
    check(wpE == 1'b0, "R1 writePermit after reset", wpE, 0);
    // R2 VCLK pulses and time alone do not leave transmit-only
    vclk = 1'b0; vclkPulses(LIMIT + 5); cyc(TMO / 2); sample();
    checkMode(modeE, TX, "R2 no exit without SCL fall");

    // R11 synchroniser latency, R2 entry on SCL fall
    @(posedge clk); #1 scl = 1'b0;
    repeat (2) @(posedge clk); sample();
    checkMode(modeE, TX, "R11 no change before third edge");
    @(posedge clk); sample();
    checkMode(modeE, TR, "R2 R11 transition after SCL fall");
    // R9 no write permit in transition even with VCLK high
    vclk = 1'b1; cyc(4); sample();
    check(wpE == 1'b0, "R9 writePermit in transition", wpE, 0);
    vclk = 1'b0; cyc(3);

    // R3 pulse-count fallback exactly at the limit (one pulse already given)
    vclkPulses(LIMIT - 2); cyc(4); sample();
    checkMode(modeE, TR, "R3 still transition after LIMIT-1 pulses");
    vclkPulses(1); cyc(4); sample();
    checkMode(modeE, TX, "R3 transmit-only after LIMIT pulses");

    // R4 timeout fallback
    sclDip(); sample();
    checkMode(modeE, TR, "R4 re-entered transition");
    cyc(TMO - 20); sample();
    checkMode(modeE, TR, "R4 before timeout");
    cyc(40); sample();
    checkMode(modeE, TX, "R4 after timeout");

    // R5 SCL fall restarts the pulse count
    sclDip();
    vclkPulses(100); sclDip();
    vclkPulses(100); cyc(4); sample();
    checkMode(modeE, TR, "R5 pulse count restarted");
    vclkPulses(LIMIT - 100); cyc(4); sample();
    checkMode(modeE, TX, "R5 fallback after fresh LIMIT pulses");

    // R5 SCL fall restarts the timeout
    sclDip();
    cyc(1500); sclDip();
    cyc(1500); sample();
    checkMode(modeE, TR, "R5 timeout restarted");
    cyc(700); sample();
    checkMode(modeE, TX, "R5 timeout after restart");

    // R6 R7 sweep of all seven-bit addresses on both instances
    for (int a = 0; a < 128; a++) begin
      logic [6:0] ad;
      ad = 7'(a);
      doReset();
      sendSelect({ad, ad[0]});
      sample();
      checkMode(modeE, (ad == 7'b1010000) ? LK : TR, $sformatf("R6 exact addr %0d", a));
      checkMode(modeW, (ad[6:3] == 4'b1010) ? LK : TR, $sformatf("R7 wide addr %0d", a));
    end

    // R8 lock survives VCLK pulses and long idle time
    doReset();
    sendSelect(8'b1010_0001);
    sample();
    checkMode(modeE, LK, "R6 lock with read bit");
    vclkPulses(LIMIT + 50); cyc(TMO + 500); sample();
    checkMode(modeE, LK, "R8 exact stays locked");
    checkMode(modeW, LK, "R8 wide stays locked");
    sclDip(); sample();
    checkMode(modeE, LK, "R8 SCL activity keeps lock");

    // R9 write permit follows VCLK when locked
    vclk = 1'b1; cyc(4); sample();
    check(wpE == 1'b1, "R9 writePermit with VCLK high", wpE, 1);
    vclk = 1'b0; cyc(4); sample();
    check(wpE == 1'b0, "R9 writePermit with VCLK low", wpE, 0);

    // R10 write-control variant, active low
    wc = 1'b0; cyc(4); sample();
    check(wpW == 1'b1, "R10 writePermit with wc low", wpW, 1);
    wc = 1'b1; vclk = 1'b1; cyc(4); sample();
    check(wpW == 1'b0, "R10 writePermit with wc high", wpW, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule